// File: doc/BRIEF.md
# Two-Channel High/Low Count Pulse Generator

This block produces two independent pulse-width-modulated outputs. Each output's waveform is given directly as two 16-bit phase lengths, a high length and a low length, and not as a period with a compare value. Each period begins with the high phase and ends with the low phase. A small 32-bit register bus sets up the block. There is one duration word per channel and one shared control word. For each channel, the control word holds a source select, a prescaler and two enables.

Four timing sources arrive as single-cycle strobes in the system clock domain. Each channel picks one of these strobes and divides it by its prescaler value plus one, which gives the length of one phase count. A new duration is held back until the running period ends, so a period is never split between two settings. Dropping a channel's enables forces its output low in the next cycle. Inversion is done in software by swapping the two counts.

Top module: `pwm_dual_hl`

## Requirements
- R1: After reset, both outputs are low and all three registers read back 0.
- R2: Byte address 0x0 holds channel 0's duration and 0x4 holds channel 1's duration, each as {high[31:16], low[15:0]}. Address 0x8 is the control word: channel 0 uses output enable bit 0, source select bits 5:4, prescaler bits 14:8 and clock enable bit 15; channel 1 uses bits 1, 7:6, 22:16 and 23. All other control bits read 0, and any other address reads 0.
- R3: A channel's output stays low unless both its clock enable and its output enable are set.
- R4: With prescaler value N, one phase count lasts N+1 strobes of the selected source.
- R5: Once enabled, a channel outputs high for `high` counts and then low for `low` counts, and this repeats.
- R6: A low count of 0 gives a low phase of exactly one count. With high = 0xFFFF and prescaler 0 on a strobe that fires every cycle, the output is low for 1 cycle in every 65536.
- R7: A high count of 0 skips the high phase, so the output stays low.
- R8: Clearing a channel's output enable drives its output low in the cycle right after the write, without finishing the period.
- R9: A duration written while the channel runs takes effect at the next period boundary. Enabling a channel always starts a fresh high phase.
- R10: Source select value k (0 to 3) times the channel's counts from strobe input bit k.
- R11: The two channels run independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_tick | input | 4 | Timing-source strobes, one per source |
| pwm_out | output | 2 | Channel outputs, bit 0 = channel 0 |

## Verification
The bench builds the block with its default parameters: two channels, 16-bit phase counts, a 7-bit prescaler and four sources. Because the full 16-bit width is kept, an all-ones high count with a zero low count can run for two complete 65536-cycle periods. That brings the single-cycle low pulse into view and lets the bench count it. Small counts, together with strobes arriving every cycle, every second cycle, every third cycle and in a pseudo-random pattern, cover the prescaler, source selection, duration updates during a period and channel independence in a few hundred cycles each.

// File: rtl/pwm_hl_pkg.sv
package pwm_hl_pkg;
  localparam int NUM_CH  = 2;
  localparam int CNT_W   = 16;
  localparam int DIV_W   = 7;
  localparam int SEL_W   = 2;
  localparam int NUM_SRC = 4;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;

  // Bit positions inside the shared control word, per channel.
  function automatic int oen_bit(input int ch);
    return ch;
  endfunction
  function automatic int sel_lsb(input int ch);
    return 4 + SEL_W * ch;
  endfunction
  function automatic int div_lsb(input int ch);
    return 8 + 8 * ch;
  endfunction
  function automatic int cen_bit(input int ch);
    return 15 + 8 * ch;
  endfunction
endpackage

// File: rtl/pwm_hl_regs.sv
module pwm_hl_regs
  import pwm_hl_pkg::*;
#(
  parameter int N_CH = NUM_CH,
  parameter int CW   = CNT_W,
  parameter int DW   = DIV_W,
  parameter int SW   = SEL_W,
  parameter int AW   = ADDR_W,
  parameter int BW   = DATA_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [AW-1:0]             addr,
  input  logic [BW-1:0]             wdata,
  output logic [BW-1:0]             rdata,
  output logic [N_CH-1:0]           run,
  output logic [N_CH-1:0][SW-1:0]   sel,
  output logic [N_CH-1:0][DW-1:0]   div,
  output logic [N_CH-1:0][CW-1:0]   hi_cnt,
  output logic [N_CH-1:0][CW-1:0]   lo_cnt
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(4 * N_CH);

  function automatic logic [BW-1:0] ctrl_mask();
    logic [BW-1:0] m;
    m = '0;
    for (int c = 0; c < N_CH; c++) begin
      m[oen_bit(c)] = 1'b1;
      m[cen_bit(c)] = 1'b1;
      for (int b = 0; b < SW; b++) m[sel_lsb(c) + b] = 1'b1;
      for (int b = 0; b < DW; b++) m[div_lsb(c) + b] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [BW-1:0] CTRL_MASK = ctrl_mask();

  logic [N_CH-1:0][BW-1:0] dur_q, dur_d;
  logic [BW-1:0]           ctrl_q, ctrl_d;

  always_comb begin
    dur_d  = dur_q;
    ctrl_d = ctrl_q;
    if (wr) begin
      for (int c = 0; c < N_CH; c++)
        if (addr == AW'(4 * c)) dur_d[c] = wdata;
      if (addr == CTRL_ADDR) ctrl_d = wdata & CTRL_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dur_q  <= '0;
      ctrl_q <= '0;
    end else begin
      dur_q  <= dur_d;
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < N_CH; c++)
      if (addr == AW'(4 * c)) rdata = dur_q[c];
    if (addr == CTRL_ADDR) rdata = ctrl_q;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_fields
    assign run[c]    = ctrl_q[oen_bit(c)] & ctrl_q[cen_bit(c)];
    assign sel[c]    = ctrl_q[sel_lsb(c) +: SW];
    assign div[c]    = ctrl_q[div_lsb(c) +: DW];
    assign hi_cnt[c] = dur_q[c][2*CW-1:CW];
    assign lo_cnt[c] = dur_q[c][CW-1:0];
  end
endmodule

// File: rtl/pwm_hl_prescale.sv
module pwm_hl_prescale
  import pwm_hl_pkg::*;
#(
  parameter int DW   = DIV_W,
  parameter int SW   = SEL_W,
  parameter int NSRC = NUM_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [NSRC-1:0] src_tick,
  input  logic [SW-1:0]   sel,
  input  logic [DW-1:0]   div,
  output logic            count_tick
);
  localparam logic [DW-1:0] DIV_ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] pcnt_q, pcnt_d;
  logic          strobe, wrap;

  always_comb begin
    strobe     = src_tick[sel];
    wrap       = (pcnt_q == div);
    count_tick = run & strobe & wrap;
    pcnt_d     = pcnt_q;
    if (!run)        pcnt_d = '0;
    else if (strobe) pcnt_d = wrap ? '0 : pcnt_q + DIV_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // Prescaler starts from zero whenever the channel is idle (R4).
  assert_idle_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pcnt_q == '0));
endmodule

// File: rtl/pwm_hl_phase.sv
module pwm_hl_phase
  import pwm_hl_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          count_tick,
  input  logic [CW-1:0] reg_hi,
  input  logic [CW-1:0] reg_lo,
  output logic          pwm
);
  localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW:0]   EXT_ONE = {{CW{1'b0}}, 1'b1};

  phase_e        phase_q, phase_d, start_ph;
  logic [CW-1:0] cnt_q, cnt_d, hi_q, hi_d, lo_q, lo_d;
  logic          last_hi, last_lo;

  always_comb begin
    start_ph = (reg_hi != '0) ? PH_HIGH : PH_LOW;
    last_hi  = (({1'b0, cnt_q} + EXT_ONE) == {1'b0, hi_q});
    last_lo  = (lo_q == '0) || (({1'b0, cnt_q} + EXT_ONE) == {1'b0, lo_q});
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    hi_d     = hi_q;
    lo_d     = lo_q;
    if (!run) begin
      phase_d = start_ph;
      cnt_d   = '0;
      hi_d    = reg_hi;
      lo_d    = reg_lo;
    end else if (count_tick) begin
      if (phase_q == PH_HIGH) begin
        if (last_hi) begin
          phase_d = PH_LOW;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end else if (last_lo) begin
        phase_d = start_ph;
        cnt_d   = '0;
        hi_d    = reg_hi;
        lo_d    = reg_lo;
      end else begin
        cnt_d = cnt_q + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
    end
  end

  assign pwm = run & (phase_q == PH_HIGH);

  // High phase never outruns its programmed length (R5).
  assert_high_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase_q == PH_HIGH) |-> (cnt_q < hi_q));
  // A zero low count yields a single-count low phase (R6).
  assert_zero_low_one_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW && lo_q == '0) |-> (cnt_q == '0));
  // A zero high count never shows a high phase (R7).
  assert_zero_high_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hi_q == '0) |-> (phase_q == PH_LOW));
  // Active durations only change at a period boundary (R9).
  assert_dur_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !count_tick) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/pwm_dual_hl.sv
module pwm_dual_hl
  import pwm_hl_pkg::*;
#(
  parameter int N_CH = NUM_CH,
  parameter int CW   = CNT_W,
  parameter int DW   = DIV_W,
  parameter int SW   = SEL_W,
  parameter int NSRC = NUM_SRC,
  parameter int AW   = ADDR_W,
  parameter int BW   = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [BW-1:0]   bus_wdata,
  output logic [BW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_tick,
  output logic [N_CH-1:0] pwm_out
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [N_CH-1:0]         run;
  logic [N_CH-1:0][SW-1:0] sel;
  logic [N_CH-1:0][DW-1:0] div;
  logic [N_CH-1:0][CW-1:0] hi_cnt, lo_cnt;

  pwm_hl_regs #(.N_CH(N_CH), .CW(CW), .DW(DW), .SW(SW), .AW(AW), .BW(BW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .run    (run),
    .sel    (sel),
    .div    (div),
    .hi_cnt (hi_cnt),
    .lo_cnt (lo_cnt)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic count_tick;

    pwm_hl_prescale #(.DW(DW), .SW(SW), .NSRC(NSRC)) u_pre (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .run        (run[c]),
      .src_tick   (src_tick),
      .sel        (sel[c]),
      .div        (div[c]),
      .count_tick (count_tick)
    );

    pwm_hl_phase #(.CW(CW)) u_phase (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .run        (run[c]),
      .count_tick (count_tick),
      .reg_hi     (hi_cnt[c]),
      .reg_lo     (lo_cnt[c]),
      .pwm        (pwm_out[c])
    );
  end
endmodule

// File: tb/tb_pwm_dual_hl.sv
`timescale 1ns/1ps
module tb_pwm_dual_hl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick;
  logic [1:0]  pwm_out;

  int    errors = 0;
  int    checks = 0;
  bit    done   = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  pwm_dual_hl dut (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .src_tick (src_tick),
    .pwm_out (pwm_out)
  );

  // Strobe sources: every cycle, every 2nd, every 3rd, pseudo-random.
  int          cyc = 0;
  logic [7:0]  lfsr = 8'hA5;
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    src_tick = {lfsr[0], (cyc % 3) == 0, (cyc % 2) == 0, 1'b1};
  end

  // Behavioural reference: position within period, compared each cycle.
  logic [31:0] m_dur [2];
  logic [31:0] m_ctrl;
  int          m_sub [2];
  int          m_pos [2];
  int          m_hi  [2];
  int          m_lo  [2];

  function automatic bit m_run(input int ch);
    return m_ctrl[ch] && m_ctrl[15 + 8 * ch];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0;
      for (int c = 0; c < 2; c++) begin
        m_dur[c] = 0; m_sub[c] = 0; m_pos[c] = 0; m_hi[c] = 0; m_lo[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int dv, sl, per;
        dv = (m_ctrl >> (8 + 8 * c)) & 127;
        sl = (m_ctrl >> (4 + 2 * c)) & 3;
        if (!m_run(c)) begin
          m_sub[c] = 0; m_pos[c] = 0;
          m_hi[c] = m_dur[c][31:16]; m_lo[c] = m_dur[c][15:0];
        end else if (src_tick[sl]) begin
          if (m_sub[c] == dv) begin
            m_sub[c] = 0;
            m_pos[c]++;
            per = m_hi[c] + ((m_lo[c] == 0) ? 1 : m_lo[c]);
            if (m_pos[c] >= per) begin
              m_pos[c] = 0;
              m_hi[c] = m_dur[c][31:16]; m_lo[c] = m_dur[c][15:0];
            end
          end else begin
            m_sub[c] = (m_sub[c] + 1) % 128;
          end
        end
      end
      if (bus_wr) begin
        if (bus_addr == 4'h0) m_dur[0] = bus_wdata;
        if (bus_addr == 4'h4) m_dur[1] = bus_wdata;
        if (bus_addr == 4'h8) m_ctrl = bus_wdata & 32'h00FF_FFF3;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      for (int c = 0; c < 2; c++) begin
        bit exp;
        exp = m_run(c) && (m_pos[c] < m_hi[c]);
        checks++;
        if (pwm_out[c] !== exp) begin
          errors++;
          $display("FAIL %s: ch%0d pwm_out=%b expected %b at cycle %0d",
                   cur_req, c, pwm_out[c], exp, cyc);
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read_check(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #0.5;
    check(req, bus_rdata, exp);
  endtask

  function automatic logic [31:0] ctl(input int ch, input bit oen, input bit cen,
                                      input int sel, input int dv);
    logic [31:0] v;
    v = 0;
    v[ch] = oen;
    v[15 + 8 * ch] = cen;
    v[4 + 2 * ch +: 2] = sel[1:0];
    v[8 + 8 * ch +: 7] = dv[6:0];
    return v;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = 32'h0; src_tick = 4'h0;
    repeat (5) @(negedge clk);
    cur_req = "R1";
    check("R1", {30'h0, pwm_out}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read_check("R1", 4'h0, 32'h0);
    bus_read_check("R1", 4'h4, 32'h0);
    bus_read_check("R1", 4'h8, 32'h0);
    check("R1", {30'h0, pwm_out}, 32'h0);
    cmp_on = 1;

    // R2: map and reserved bits (durations zero, so outputs remain low)
    cur_req = "R2";
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_read_check("R2", 4'h8, 32'h00FF_FFF3);
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, 32'h1234_5678);
    bus_write(4'h4, 32'h9ABC_DEF0);
    bus_read_check("R2", 4'h0, 32'h1234_5678);
    bus_read_check("R2", 4'h4, 32'h9ABC_DEF0);
    bus_read_check("R2", 4'hC, 32'h0);

    // R3: one enable alone keeps output low
    cur_req = "R3";
    bus_write(4'h0, {16'd5, 16'd5});
    bus_write(4'h8, ctl(0, 1, 0, 0, 0));
    repeat (30) @(negedge clk);
    check("R3", {31'h0, pwm_out[0]}, 32'h0);
    bus_write(4'h8, ctl(0, 0, 1, 0, 0));
    repeat (30) @(negedge clk);
    check("R3", {31'h0, pwm_out[0]}, 32'h0);

    // R4, R5, R11: both channels, different prescale and sources
    cur_req = "R4 R5 R11";
    bus_write(4'h0, {16'd3, 16'd2});
    bus_write(4'h4, {16'd2, 16'd4});
    bus_write(4'h8, ctl(0, 1, 1, 0, 1) | ctl(1, 1, 1, 1, 0));
    check("R5", {31'h0, pwm_out[0]}, 32'h1);
    repeat (5) @(negedge clk);
    check("R4", {31'h0, pwm_out[0]}, 32'h1);
    @(negedge clk);
    check("R4", {31'h0, pwm_out[0]}, 32'h0);
    repeat (200) @(negedge clk);

    // R10: other sources
    cur_req = "R10";
    bus_write(4'h8, ctl(0, 1, 1, 2, 0) | ctl(1, 1, 1, 3, 2));
    repeat (200) @(negedge clk);

    // R9: duration change mid-period lands at the boundary
    cur_req = "R9";
    bus_write(4'h0, {16'd7, 16'd3});
    bus_write(4'h8, ctl(0, 1, 1, 0, 0));
    repeat (3) @(negedge clk);
    bus_write(4'h0, {16'd2, 16'd2});
    check("R9", {31'h0, pwm_out[0]}, 32'h1);
    repeat (60) @(negedge clk);

    // R8: disable during high phase
    cur_req = "R8";
    bus_write(4'h0, {16'd50, 16'd3});
    bus_write(4'h8, 32'h0);
    bus_write(4'h8, ctl(0, 1, 1, 0, 0));
    repeat (10) @(negedge clk);
    check("R8", {31'h0, pwm_out[0]}, 32'h1);
    bus_write(4'h8, ctl(0, 0, 1, 0, 0));
    check("R8", {31'h0, pwm_out[0]}, 32'h0);

    // R7: zero high count
    cur_req = "R7";
    bus_write(4'h0, {16'd0, 16'd5});
    bus_write(4'h8, ctl(0, 1, 1, 0, 0));
    begin
      int highs;
      highs = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (pwm_out[0]) highs++;
      end
      check("R7", highs, 0);
    end

    // R6: zero low count, full high count, one low cycle per 65536
    cur_req = "R6";
    bus_write(4'h8, 32'h0);
    bus_write(4'h4, {16'hFFFF, 16'h0});
    bus_write(4'h8, ctl(1, 1, 1, 0, 0));
    begin
      int lows;
      lows = 0;
      for (int i = 0; i < 131072; i++) begin
        if (i > 0) @(negedge clk);
        if (!pwm_out[1]) lows++;
      end
      check("R6", lows, 2);
    end

    @(negedge clk);
    finish_run();
  end
endmodule